// File: doc/BRIEF.md
# Per-Port Destination Address Filter

This block sits at the ingress of a multi-port packet pipeline and decides, frame by frame, whether an arriving frame goes any further. Each Ethernet port has a 48-bit station address that software loads over a small register interface. When a frame starts, the block takes the destination address from the first beat. It compares that address with the station address of the port named by the frame's source-port tag. A frame addressed to that port passes. A frame whose destination has the group bit set also passes. Every other frame from an Ethernet port is removed entirely: no beat of it leaves the block, and nothing is raised toward the CPU.

Frames are carried as 64-bit beats with start and end markers and a port tag. The destination address sits in the top 48 bits of the start beat, so the decision is complete as soon as that beat arrives. Tags from `NUM_PORTS` upward mark frames that come from the CPU, and these frames are never filtered. Frames that pass leave one cycle later with their contents unchanged. A counter records how many frames have been filtered, and software reads it through the same register interface.

Top module: `mac_filt_top`

## Requirements
- R1: A start beat from Ethernet port p (tag < NUM_PORTS) whose destination, in_data[63:16], equals the station address of port p passes together with the rest of its frame.
- R2: A frame whose first destination byte (in_data[63:56]) has its least significant bit, in_data[56], set passes whatever the station addresses hold.
- R3: A frame from an Ethernet port that matches neither R1 nor R2 is removed whole, from its start beat to its end beat, including single-beat frames; out_valid stays low for all of its beats.
- R4: Each port is matched only against its own station address; the address of a different port does not admit a frame.
- R5: Frames with a tag of NUM_PORTS or above (CPU path) always pass.
- R6: A passing beat appears on the outputs exactly one cycle after it is presented, with data, port, start and end markers unchanged; back-to-back frames need no idle cycle.
- R7: Register map: word 2p holds bits 31:0 of port p's address, word 2p+1 holds bits 47:32 in bits 15:0; a read strobe returns the word on reg_rdata in the following cycle, and reg_rdata holds its value otherwise. All station addresses reset to zero.
- R8: Word 2*NUM_PORTS reads the filtered-frame count, which resets to zero and rises by one for each frame removed under R3; writes to that word are ignored.
- R9: An address write that lands while a frame is in flight, including the cycle of its start beat, does not change that frame's fate; it applies from the next start beat on.
- R10: After reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_sof | input | 1 | Input beat starts a frame |
| in_eof | input | 1 | Input beat ends a frame |
| in_port | input | PORT_W | Source-port tag of the frame |
| in_data | input | DATA_W | Beat data; destination address in bits 63:16 of the start beat |
| out_valid | output | 1 | Output beat valid |
| out_sof | output | 1 | Output beat starts a frame |
| out_eof | output | 1 | Output beat ends a frame |
| out_port | output | PORT_W | Source-port tag of the output beat |
| out_data | output | DATA_W | Output beat data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |

## Verification
The assertions check four things on every cycle. Passing beats come out one cycle later with the same content. Group-addressed and CPU-tagged beats are never removed. Once a frame's start beat is removed, none of its later beats come out. Read data changes only after a read strobe. Some behaviour needs the stored addresses, so only the bench's scenarios can show it: the exact-match accept, the cross-port rejection, the filtered-frame count, the write-only-at-boundary timing and the register readback.

// File: rtl/mac_filt_pkg.sv
// Shared types for the destination address filter.
// Assumes a station address is 48 bits wide.
package mac_filt_pkg;
    localparam int MAC_W = 48;
    typedef logic [MAC_W-1:0] mac_t;
endpackage

// File: rtl/mac_filt_regs.sv
// Station address store and filtered-frame counter, with a word-wide
// register port. Word 2p/2p+1 = low/high part of port p, word 2*NUM_PORTS
// = counter (read only). Assumes CNT_W <= 32.
module mac_filt_regs
    import mac_filt_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 4,
    parameter int CNT_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              drop_pulse,
    output logic [31:0]       reg_rdata,
    output mac_t              mac_o [NUM_PORTS]
);
    localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(2 * NUM_PORTS);

    mac_t             mac_q [NUM_PORTS];
    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      rd_val;

    // Load station address halves on writes to their word.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (!rst_n) begin
                mac_q[p] <= '0;
            end else if (reg_wr && reg_addr == ADDR_W'(2 * p)) begin
                mac_q[p][31:0] <= reg_wdata;
            end else if (reg_wr && reg_addr == ADDR_W'(2 * p + 1)) begin
                mac_q[p][MAC_W-1:32] <= reg_wdata[MAC_W-33:0];
            end
        end
    end

    // Count frames removed by the filter.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (drop_pulse) cnt_q <= cnt_q + 1'b1;
    end

    // Select the word addressed by the read port.
    always_comb begin
        rd_val = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (reg_addr == ADDR_W'(2 * p)) rd_val = mac_q[p][31:0];
            if (reg_addr == ADDR_W'(2 * p + 1)) rd_val = {16'b0, mac_q[p][MAC_W-1:32]};
        end
        if (reg_addr == CNT_ADDR) rd_val = 32'(cnt_q);
    end

    // Capture read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_val;
    end

    assign mac_o = mac_q;
endmodule

// File: rtl/mac_filt_decide.sv
// Accept/reject decision for one start beat. Combinational.
// Assumes dest holds the destination address with byte 0 in bits 47:40.
module mac_filt_decide
    import mac_filt_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 3
) (
    input  logic [PORT_W-1:0] in_port,
    input  mac_t              dest,
    input  mac_t              mac_i [NUM_PORTS],
    output logic              accept
);
    logic [NUM_PORTS-1:0] hit;
    logic                 from_cpu;
    logic                 group_bit;

    // One comparator per port, each gated by the port tag.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_cmp
        assign hit[p] = (in_port == PORT_W'(p)) && (dest == mac_i[p]);
    end

    assign from_cpu  = {1'b0, in_port} >= (PORT_W + 1)'(NUM_PORTS);
    assign group_bit = dest[MAC_W-8];
    assign accept    = from_cpu | group_bit | (|hit);
endmodule

// File: rtl/mac_filt_pass.sv
// Output stage: holds the per-frame drop state and registers passing beats.
// Assumes the port tag is constant within a frame and no backpressure.
module mac_filt_pass #(
    parameter int PORT_W = 3,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [PORT_W-1:0] in_port,
    input  logic [DATA_W-1:0] in_data,
    input  logic              accept,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eof,
    output logic [PORT_W-1:0] out_port,
    output logic [DATA_W-1:0] out_data,
    output logic              drop_pulse
);
    logic drop_q;
    logic drop_now;
    logic sof_beat;

    assign sof_beat   = in_valid & in_sof;
    assign drop_now   = sof_beat ? ~accept : drop_q;
    assign drop_pulse = sof_beat & ~accept;

    // Remember a rejected frame until its end beat.
    always_ff @(posedge clk) begin
        if (!rst_n) drop_q <= 1'b0;
        else if (sof_beat && !in_eof) drop_q <= ~accept;
        else if (in_valid && in_eof) drop_q <= 1'b0;
    end

    // Register passing beats toward the next stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_port  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid & ~drop_now;
            out_sof   <= in_valid & ~drop_now & in_sof;
            out_eof   <= in_valid & ~drop_now & in_eof;
            out_port  <= in_port;
            out_data  <= in_data;
        end
    end
endmodule

// File: rtl/mac_filt_top.sv
// Per-port destination address filter. Frames from Ethernet ports pass only
// if addressed to the ingress port's station address or group addressed;
// CPU-tagged frames (tag >= NUM_PORTS) always pass. Assumes DATA_W >= 48.
module mac_filt_top
    import mac_filt_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 3,
    parameter int DATA_W    = 64,
    parameter int ADDR_W    = 4,
    parameter int CNT_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [PORT_W-1:0] in_port,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eof,
    output logic [PORT_W-1:0] out_port,
    output logic [DATA_W-1:0] out_data,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    localparam int DA_LSB = DATA_W - MAC_W;

    mac_t mac_w [NUM_PORTS];
    mac_t dest;
    logic accept;
    logic drop_pulse;

    assign dest = in_data[DATA_W-1:DA_LSB];

    mac_filt_regs #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .drop_pulse(drop_pulse),
        .reg_rdata(reg_rdata), .mac_o(mac_w)
    );

    mac_filt_decide #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_decide (
        .in_port(in_port), .dest(dest), .mac_i(mac_w), .accept(accept)
    );

    mac_filt_pass #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_pass (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_port(in_port), .in_data(in_data), .accept(accept),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
        .out_port(out_port), .out_data(out_data), .drop_pulse(drop_pulse)
    );
endmodule

// File: rtl/mac_filt_chk.sv
// Property checker for mac_filt_top, attached by bind below.
module mac_filt_chk #(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 3,
    parameter int DATA_W    = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sof,
    input logic              in_eof,
    input logic [PORT_W-1:0] in_port,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_sof,
    input logic [PORT_W-1:0] out_port,
    input logic [DATA_W-1:0] out_data,
    input logic              reg_rd,
    input logic [31:0]       reg_rdata
);
    logic pend_q;
    logic gone_q;
    logic cpu_tag;

    assign cpu_tag = {1'b0, in_port} >= (PORT_W + 1)'(NUM_PORTS);

    // Track a multi-beat frame whose start beat did not come out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            gone_q <= 1'b0;
        end else begin
            pend_q <= in_valid & in_sof & ~in_eof;
            if (in_valid && in_eof) gone_q <= 1'b0;
            else if (pend_q && !out_valid) gone_q <= 1'b1;
        end
    end

    a_r6_beat_copy: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid) && out_data == $past(in_data) && out_port == $past(in_port)));

    a_r5_cpu_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cpu_tag) |=> out_valid);

    a_r2_group_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && in_data[DATA_W-8]) |=> (out_valid && out_sof));

    a_r3_whole_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sof && (gone_q || (pend_q && !out_valid))) |=> !out_valid);

    a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

bind mac_filt_top mac_filt_chk #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_port(in_port), .in_data(in_data), .out_valid(out_valid), .out_sof(out_sof),
    .out_port(out_port), .out_data(out_data), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
);

// File: tb/tb_mac_filt_top.sv
// Scoreboard bench: the driver queues expected beats, the monitor compares.
module tb_mac_filt_top;
    localparam int NP = 4;
    localparam int PW = 3;
    localparam int DW = 64;
    localparam int AW = 4;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [PW-1:0] port;
        logic          sof;
        logic          eof;
    } beat_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [PW-1:0] in_port = '0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid, out_sof, out_eof;
    logic [PW-1:0] out_port;
    logic [DW-1:0] out_data;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;

    int checks = 0;
    int fails = 0;
    int drops = 0;
    int seq = 0;
    logic [47:0] model [NP];
    beat_t exp_q[$];
    string cur_req = "R6";

    always #5 clk = ~clk;

    mac_filt_top #(.NUM_PORTS(NP), .PORT_W(PW), .DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_port(in_port), .in_data(in_data), .out_valid(out_valid), .out_sof(out_sof),
        .out_eof(out_eof), .out_port(out_port), .out_data(out_data), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Monitor: every output beat must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check({cur_req, " unexpected beat"}, out_data, 64'h0);
                if (out_data == 64'h0) begin
                    fails++;
                    $display("FAIL %s unexpected beat actual=%h expected=none", cur_req, out_data);
                end
            end else begin
                beat_t e;
                e = exp_q.pop_front();
                check({cur_req, " beat"}, {out_data}, e.data);
                check({cur_req, " tag/markers"}, 64'({out_port, out_sof, out_eof}),
                      64'({e.port, e.sof, e.eof}));
            end
        end
    end

    task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a < AW'(2 * NP)) begin
            if (a[0]) model[a >> 1][47:32] = d[15:0];
            else model[a >> 1][31:0] = d;
        end
    endtask

    task automatic reg_read(input logic [AW-1:0] a, input logic [31:0] expv, input string req);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        check(req, 64'(reg_rdata), 64'(expv));
    endtask

    // Drive one frame; optionally write a register during beat 1.
    task automatic send_frame(input logic [PW-1:0] p, input logic [47:0] da, input int nb,
                              input bit mid_wr, input logic [AW-1:0] wa, input logic [31:0] wd);
        bit pass;
        pass = (p >= PW'(NP)) || da[40] || (da == model[p]);
        if (!pass) drops++;
        seq++;
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_port = p;
            in_sof = (i == 0); in_eof = (i == nb - 1);
            in_data = (i == 0) ? {da, 16'(seq)} : {16'hBEEF, 16'(seq), 16'(i), 16'h1234};
            reg_wr = mid_wr && (i == 1);
            reg_addr = wa; reg_wdata = wd;
            if (pass) exp_q.push_back('{data: in_data, port: p, sof: in_sof, eof: in_eof});
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; reg_wr = 1'b0;
        if (mid_wr) begin
            if (wa[0]) model[wa >> 1][47:32] = wd[15:0];
            else model[wa >> 1][31:0] = wd;
        end
    endtask

    task automatic drain(input string req);
        repeat (3) @(negedge clk);
        check({req, " queue drained"}, 64'(exp_q.size()), 64'h0);
        exp_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) model[p] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 out_valid after reset", 64'(out_valid), 64'h0);
        reg_read(AW'(0), 32'h0, "R7 reset address");
        reg_read(AW'(2 * NP), 32'h0, "R8 reset count");

        for (int p = 0; p < NP; p++) begin
            reg_write(AW'(2 * p), 32'h0000_1100 + 32'(p));
            reg_write(AW'(2 * p + 1), 32'h0000_0200 + 32'(p));
        end
        reg_read(AW'(2), 32'h0000_1101, "R7 port1 low");
        reg_read(AW'(7), 32'h0000_0203, "R7 port3 high");

        cur_req = "R1";
        send_frame(3'd0, model[0], 3, 0, '0, '0);
        send_frame(3'd2, model[2], 1, 0, '0, '0);
        drain("R1");

        cur_req = "R4";
        send_frame(3'd1, model[0], 3, 0, '0, '0);
        send_frame(3'd3, model[1], 2, 0, '0, '0);
        drain("R4");

        cur_req = "R3";
        send_frame(3'd2, 48'h0A00_DEAD_BEEF, 4, 0, '0, '0);
        send_frame(3'd0, 48'h0A00_0000_0001, 1, 0, '0, '0);
        send_frame(3'd1, model[1], 2, 0, '0, '0);
        drain("R3");

        cur_req = "R2";
        send_frame(3'd3, 48'hFFFF_FFFF_FFFF, 2, 0, '0, '0);
        send_frame(3'd1, 48'h0100_5E00_0001, 3, 0, '0, '0);
        drain("R2");

        cur_req = "R5";
        send_frame(3'd4, 48'h0A00_1234_5678, 3, 0, '0, '0);
        send_frame(3'd7, 48'h0000_0000_0000, 1, 0, '0, '0);
        drain("R5");

        cur_req = "R9";
        send_frame(3'd0, model[0], 4, 1, AW'(0), 32'h0000_7777);
        send_frame(3'd0, 48'h0200_0000_1100, 2, 0, '0, '0);
        send_frame(3'd0, model[0], 2, 0, '0, '0);
        drain("R9");

        reg_read(AW'(2 * NP), 32'(drops), "R8 drop count");
        reg_write(AW'(2 * NP), 32'h0000_00AA);
        reg_read(AW'(2 * NP), 32'(drops), "R8 write ignored");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule